// File: doc/BRIEF.md
# Lightpipe Frame Transmitter

This block serialises a multichannel digital audio stream onto one optical-style serial line. Each sample period it sends a 256-bit frame carrying eight 24-bit channel samples and four user bits. The line is NRZI coded: a '1' bit flips the line level and a '0' bit holds it, so the absolute level carries no meaning. A frame opens with a ten-bit run of zeros that a receiver uses to find frame boundaries. Every other group of at most four data bits is followed by a forced '1', so a gap of more than five bit times without a transition can only appear at the sync field.

The block runs from a free-running system clock and advances one bit on each single-cycle `bit_en` pulse, which upstream logic derives from the line bit rate. On the pulse that sends bit 0 of a frame, the block copies all eight samples and the user bits into its own frame store. Inputs may then change freely for the rest of the frame. `ready` is high while the next pulse will take new samples. `frame_start` pulses after that capture, which gives the source a whole frame period to present the next set.

A three-state machine walks the frame. SYNC is left for HEAD once the tenth sync bit has been sent. HEAD is left for AUDIO once its sixth bit has been sent. AUDIO loops over the channels, nibbles and separators and returns to SYNC after the separator that ends the last nibble of channel 8. An 8-bit frame position counter runs beside the state machine and wraps from 255 to 0 on that same step.

Top module: `lightpipe_tx`

## Requirements
- R1: The frame position advances by exactly one bit on each clock where `bit_en` is high. On a clock without `bit_en`, `line_out` and the frame position do not change.
- R2: Line coding is NRZI. On a `bit_en` clock, a '1' bit inverts `line_out` at that edge and a '0' bit leaves it unchanged.
- R3: Frame bits 0 to 9 form the sync field and are all '0'.
- R4: Bit 10 is '1'. Bits 11 to 14 are `user_in[3]`, `user_in[2]`, `user_in[1]` and `user_in[0]`, in that order. Bit 15 is '1'.
- R5: Channel k (k = 0 to 7) is taken from `ch_data[24k+23:24k]` and fills bits 16+30k to 45+30k, channel 0 first. Its nibble j (j = 0 to 5) is sent as sample bits 23-4j down to 20-4j, most significant first, followed by a '1' separator.
- R6: Outside the sync field, no more than four consecutive '0' bits are sent.
- R7: All channel samples and the user bits are captured at the `bit_en` edge that sends bit 0. Input changes at any other time have no effect on the frame in progress.
- R8: A frame is exactly 256 bits long. After bit 255 is sent, the next `bit_en` sends bit 0 of a new frame.
- R9: `frame_start` is high for exactly the one clock that follows the edge sending bit 0. `ready` is high exactly while the next `bit_en` would send bit 0.
- R10: During and straight after reset, `line_out` is low, `frame_start` is low, `ready` is high and the frame position is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Single-cycle pulse, one per line bit |
| ch_data | input | 192 | Eight 24-bit samples, channel 0 in bits 23:0 |
| user_in | input | 4 | User bits sent in the frame header |
| line_out | output | 1 | NRZI-coded serial line |
| frame_start | output | 1 | One-clock pulse after bit 0 of a frame is sent |
| ready | output | 1 | The next `bit_en` will capture new samples |

## Verification
The embedded properties take `bit_en` as a plain single-cycle strobe that may sit high on consecutive clocks but never means more than one bit per clock. They also take `rst_n` as asserted from time zero. The bench keeps within this: a generator drives `bit_en` at falling edges with gaps of zero to three idle clocks, and it issues only as many pulses as the scoreboard holds expected bits. In between frames the stream therefore stalls while `ready` is high, which exercises the hold behaviour. Inputs change only at falling edges: once just before the capturing pulse, and once inverted mid-frame so that the capture rule is tested.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_HEAD  = 2'd1,
        ST_AUDIO = 2'd2
    } lp_state_e;

    function automatic int lp_frame_bits(input int sync_len, input int user_w,
                                         input int channels, input int sample_w,
                                         input int nib_w);
        return sync_len + user_w + 2 + channels * (sample_w / nib_w) * (nib_w + 1);
    endfunction

endpackage

// File: rtl/lp_framer.sv
module lp_framer
    import lp_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int SAMPLE_W = 24,
    parameter int NIB_W    = 4,
    parameter int USER_W   = 4,
    parameter int SYNC_LEN = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic [CHANNELS*SAMPLE_W-1:0] ch_data,
    input  logic [USER_W-1:0]            user_in,
    output logic                         bit_val,
    output logic                         first_bit,
    output logic                         ready
);

    localparam int NIBS      = SAMPLE_W / NIB_W;
    localparam int GROUP     = NIB_W + 1;
    localparam int HEAD_LEN  = USER_W + 2;
    localparam int FRAME_LEN = lp_frame_bits(SYNC_LEN, USER_W, CHANNELS, SAMPLE_W, NIB_W);
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int SUB_W     = $clog2((HEAD_LEN > GROUP) ? HEAD_LEN : GROUP);
    localparam int NIB_IW    = $clog2(NIBS);
    localparam int CH_W      = $clog2(CHANNELS);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0]  SYNC_END  = CNT_W'(SYNC_LEN - 1);
    localparam logic [SUB_W-1:0]  HEAD_END  = SUB_W'(HEAD_LEN - 1);
    localparam logic [SUB_W-1:0]  GRP_END   = SUB_W'(GROUP - 1);
    localparam logic [NIB_IW-1:0] NIB_END   = NIB_IW'(NIBS - 1);
    localparam logic [CH_W-1:0]   CH_END    = CH_W'(CHANNELS - 1);

    lp_state_e                   st_q, st_d;
    logic [CNT_W-1:0]            cnt_q, cnt_d;
    logic [SUB_W-1:0]            sub_q, sub_d;
    logic [NIB_IW-1:0]           nib_q, nib_d;
    logic [CH_W-1:0]             ch_q, ch_d;
    logic [CHANNELS*SAMPLE_W-1:0] store_q;
    logic [USER_W-1:0]           user_q;
    logic [SAMPLE_W-1:0]         lane [CHANNELS];
    logic [SAMPLE_W-1:0]         word_sh;
    logic [USER_W-1:0]           user_sh;

    assign ready     = (st_q == ST_SYNC) && (cnt_q == '0);
    assign first_bit = bit_en && ready;

    // Per-channel view of the frame store
    generate
        for (genvar k = 0; k < CHANNELS; k++) begin : g_lane
            assign lane[k] = store_q[k*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    // Frame store: whole frame captured on the pulse that sends bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
            user_q  <= '0;
        end else if (first_bit) begin
            store_q <= ch_data;
            user_q  <= user_in;
        end
    end

    // State register and position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SYNC;
            cnt_q <= '0;
            sub_q <= '0;
            nib_q <= '0;
            ch_q  <= '0;
        end else if (bit_en) begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sub_q <= sub_d;
            nib_q <= nib_d;
            ch_q  <= ch_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        sub_d = sub_q;
        nib_d = nib_q;
        ch_d  = ch_q;
        cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        unique case (st_q)
            ST_SYNC: begin
                if (cnt_q == SYNC_END) begin
                    st_d  = ST_HEAD;
                    sub_d = '0;
                end
            end
            ST_HEAD: begin
                if (sub_q == HEAD_END) begin
                    st_d  = ST_AUDIO;
                    sub_d = '0;
                    nib_d = '0;
                    ch_d  = '0;
                end else begin
                    sub_d = sub_q + 1'b1;
                end
            end
            ST_AUDIO: begin
                if (sub_q == GRP_END) begin
                    sub_d = '0;
                    if (nib_q == NIB_END) begin
                        nib_d = '0;
                        if (ch_q == CH_END) begin
                            ch_d = '0;
                            st_d = ST_SYNC;
                        end else begin
                            ch_d = ch_q + 1'b1;
                        end
                    end else begin
                        nib_d = nib_q + 1'b1;
                    end
                end else begin
                    sub_d = sub_q + 1'b1;
                end
            end
            default: st_d = ST_SYNC;
        endcase
    end

    // Output: value of the bit at the current position
    always_comb begin
        bit_val = 1'b0;
        word_sh = '0;
        user_sh = '0;
        unique case (st_q)
            ST_SYNC: bit_val = 1'b0;
            ST_HEAD: begin
                if (sub_q == '0 || sub_q == HEAD_END) begin
                    bit_val = 1'b1;
                end else begin
                    user_sh = user_q << (int'(sub_q) - 1);
                    bit_val = user_sh[USER_W-1];
                end
            end
            ST_AUDIO: begin
                if (sub_q == GRP_END) begin
                    bit_val = 1'b1;
                end else begin
                    word_sh = lane[ch_q] << (int'(nib_q) * NIB_W + int'(sub_q));
                    bit_val = word_sh[SAMPLE_W-1];
                end
            end
            default: bit_val = 1'b0;
        endcase
    end

    // Checker state: zeros sent since the last '1'
    logic [CNT_W-1:0] zrun_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      zrun_q <= '0;
        else if (bit_en) zrun_q <= bit_val ? '0 : zrun_q + 1'b1;
    end

    AST_SYNC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC) |-> (cnt_q < CNT_W'(SYNC_LEN))); // R3
    AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st_q != ST_SYNC && !bit_val) |-> (zrun_q < CNT_W'(NIB_W))); // R6
    AST_END_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st_q == ST_AUDIO && sub_q == GRP_END && nib_q == NIB_END && ch_q == CH_END)
        |-> (cnt_q == CNT_LAST)); // R8
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cnt_q == CNT_LAST) |=> (ready)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cnt_q)); // R1
    AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !first_bit |=> ($stable(store_q) && $stable(user_q))); // R7
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        first_bit |=> !ready); // R9

endmodule

// File: rtl/lp_nrzi.sv
module lp_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_val,
    output logic line_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                line_out <= 1'b0;
        else if (bit_en && bit_val) line_out <= ~line_out;
    end

    AST_ONE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_val) |=> (line_out != $past(line_out))); // R2
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && bit_val) |=> $stable(line_out)); // R2

endmodule

// File: rtl/lightpipe_tx.sv
module lightpipe_tx #(
    parameter int CHANNELS = 8,
    parameter int SAMPLE_W = 24,
    parameter int NIB_W    = 4,
    parameter int USER_W   = 4,
    parameter int SYNC_LEN = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_en,
    input  logic [CHANNELS*SAMPLE_W-1:0] ch_data,
    input  logic [USER_W-1:0]            user_in,
    output logic                         line_out,
    output logic                         frame_start,
    output logic                         ready
);

    logic bit_val;
    logic first_bit;

    lp_framer #(
        .CHANNELS (CHANNELS),
        .SAMPLE_W (SAMPLE_W),
        .NIB_W    (NIB_W),
        .USER_W   (USER_W),
        .SYNC_LEN (SYNC_LEN)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .ch_data   (ch_data),
        .user_in   (user_in),
        .bit_val   (bit_val),
        .first_bit (first_bit),
        .ready     (ready)
    );

    lp_nrzi u_nrzi (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_val  (bit_val),
        .line_out (line_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= first_bit;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R9
    AST_START_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && ready) |=> frame_start); // R9

endmodule

// File: tb/tb_lightpipe_tx.sv
module tb_lightpipe_tx;

    localparam int CH = 8;
    localparam int SW = 24;
    localparam int UW = 4;
    localparam int FL = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic [CH*SW-1:0] ch_data = '0;
    logic [UW-1:0]    user_in = '0;
    logic             line_out;
    logic             frame_start;
    logic             ready;

    lightpipe_tx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .ch_data     (ch_data),
        .user_in     (user_in),
        .line_out    (line_out),
        .frame_start (frame_start),
        .ready       (ready)
    );

    always #4 clk = ~clk;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    bit   mon_on = 1'b0;
    bit   exp_q[$];
    int   exp_total = 0;
    int   issued = 0;
    int   gap = 0;
    logic en_d = 1'b0;

    always @(posedge clk) en_d <= bit_en;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected frame content, built from R3, R4 and R5
    function automatic void push_frame(input logic [CH*SW-1:0] d, input logic [UW-1:0] u);
        for (int i = 0; i < 10; i++) exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
        for (int i = UW-1; i >= 0; i--) exp_q.push_back(u[i]);
        exp_q.push_back(1'b1);
        for (int k = 0; k < CH; k++)
            for (int j = 0; j < 6; j++) begin
                for (int t = 0; t < 4; t++) exp_q.push_back(d[k*SW + SW-1 - 4*j - t]);
                exp_q.push_back(1'b1);
            end
        exp_total += FL;
    endfunction

    // Bit strobe generator: only as many pulses as expected bits
    initial begin
        int idle;
        idle = 0;
        forever begin
            @(negedge clk);
            if (issued < exp_total && idle >= gap) begin
                bit_en = 1'b1;
                issued++;
                idle = 0;
            end else begin
                bit_en = 1'b0;
                idle++;
            end
        end
    end

    // Driver: waits for ready, presents samples, scrambles them mid-frame
    task automatic send_frame(input logic [CH*SW-1:0] d, input logic [UW-1:0] u, input int g);
        @(negedge clk);
        while (!ready) @(negedge clk);
        ch_data = d;
        user_in = u;
        gap     = g;
        push_frame(d, u);
        @(negedge clk);
        while (!frame_start) @(negedge clk);
        ch_data = ~d;   // R7: must not reach the frame in progress
        user_in = ~u;
    endtask

    // Monitor: decodes NRZI and compares against the scoreboard
    initial begin
        logic  last_line;
        bit    dec;
        bit    expb;
        int    idx;
        int    zrun;
        int    maxrun;
        string tag;
        last_line = 1'b0;
        idx = 0;
        zrun = 0;
        maxrun = 0;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (en_d) begin
                    dec = line_out ^ last_line;
                    last_line = line_out;
                    if (idx < 10)      tag = "R3";
                    else if (idx < 16) tag = "R4";
                    else               tag = "R5/R7";
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", "bit sent with no expectation", int'(dec), 0);
                    end else begin
                        expb = exp_q.pop_front();
                        check(dec == expb, tag, $sformatf("R2 decoded bit %0d", idx),
                              int'(dec), int'(expb));
                    end
                    check(frame_start == (idx == 0), "R8/R9", $sformatf("frame_start at bit %0d", idx),
                          int'(frame_start), int'(idx == 0));
                    if (idx >= 10) begin
                        zrun = dec ? 0 : zrun + 1;
                        if (zrun > maxrun) maxrun = zrun;
                    end
                    if (idx == FL-1) begin
                        check(maxrun <= 4, "R6", "longest zero run outside sync", maxrun, 4);
                        maxrun = 0;
                        zrun = 0;
                    end
                    idx = (idx + 1) % FL;
                end else begin
                    check(line_out == last_line, "R1", "line held without bit_en",
                          int'(line_out), int'(last_line));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    function automatic logic [CH*SW-1:0] pattern(input int p);
        logic [CH*SW-1:0] v;
        for (int k = 0; k < CH; k++) begin
            case (p)
                0: v[k*SW +: SW] = 24'h000000;
                1: v[k*SW +: SW] = 24'hFFFFFF;
                2: v[k*SW +: SW] = 24'h5A5A5A ^ (24'h111111 * (k + 1));
                3: v[k*SW +: SW] = 24'h000001 << (3 * k);
                default: v[k*SW +: SW] = 24'h800001 | (24'h010100 * k);
            endcase
        end
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(line_out == 1'b0, "R10", "line during reset", int'(line_out), 0);
        check(frame_start == 1'b0, "R10", "frame_start during reset", int'(frame_start), 0);
        check(ready == 1'b1, "R10", "ready during reset", int'(ready), 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(line_out == 1'b0, "R1", "line idle without bit_en", int'(line_out), 0);
        check(ready == 1'b1, "R10", "ready after reset", int'(ready), 1);
        mon_on = 1'b1;

        send_frame(pattern(0), 4'h0, 1);
        send_frame(pattern(1), 4'hF, 0);
        send_frame(pattern(2), 4'hA, 3);
        send_frame(pattern(3), 4'h5, 2);
        send_frame(pattern(4), 4'h3, 0);

        while (issued < exp_total || exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        check(ready == 1'b1, "R9", "ready after final frame", int'(ready), 1);
        check(frame_start == 1'b0, "R9", "frame_start idle", int'(frame_start), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule